// File: doc/BRIEF.md
# Bus initiator retry limiter

This block watches one bus-master transaction at a time. A start pulse opens a transaction and records whether it is a read or a write. After that, each attempt reports a two-bit termination code. When the target asks for a retry, the block either requests a re-issue or, once the programmed retry budget is spent, requests an abort and flags a retry error. A master abort or a target abort from the bus ends the transaction at once. A normal completion ends it without any flag.

The three kinds of abnormal ending are kept in sticky status bits, which software clears by writing ones to them. Each status bit has its own interrupt enable. A masked status bit is still set, so software can find it by polling. When a read ends in any abort, the block also sends a one-cycle transfer-error pulse toward the host.

Setup goes through a small write port. Address 0 holds the retry limit and the enables. Address 1 clears status bits.

Top module: `retry_guard`

## Requirements
- R1: After reset the block is idle. The status bits, irq, reissue, abort_req and xfer_err are all 0. The retry limit is 0xFF and all three interrupt enables are 0.
- R2: The retry count clears when a transaction is accepted. Retries counted in one transaction never shorten the budget of the next one.
- R3: With a limit of 0, every retry response (code 2'b01) gives a reissue pulse, and the transaction is never aborted for retries.
- R4: With a limit N from 1 to 255, each of the first N retries of a transaction gives a one-cycle reissue pulse. The retry after those N gives an abort_req pulse, sets status bit 0 and ends the transaction.
- R5: Code 2'b10 (master abort) ends the transaction at once and sets status bit 1. Code 2'b11 (target abort) ends it at once and sets status bit 2. Neither code gives abort_req, whatever the retry count.
- R6: A write transaction that ends in any abort never raises xfer_err.
- R7: A read transaction that ends in any of the three aborts gives a one-cycle xfer_err pulse. The pulse comes in the same cycle as the abort report, which is the cycle after the attempt is sampled.
- R8: irq is the OR of each status bit ANDed with its enable. A status bit is set whether or not its enable is 1.
- R9: Status bits stay set until a write to address 1 carries a 1 in the matching position of cfg_wdata[2:0].
- R10: A start while a transaction is active is ignored, and so is its direction; the retry count carries on. An attempt while idle has no effect.
- R11: A write to address 0 loads the limit from cfg_wdata[7:0] and the enables from cfg_wdata[8] (retry error), cfg_wdata[9] (master abort) and cfg_wdata[10] (target abort).
- R12: Code 2'b00 ends the transaction with no pulse and no status change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Open a transaction (only acted on while idle) |
| start_rd | input | 1 | Direction of the new transaction, 1 = read |
| att_valid | input | 1 | An attempt result is present |
| att_code | input | 2 | Termination code: 00 done, 01 retry, 10 master abort, 11 target abort |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = limit and enables, 1 = status clear |
| cfg_wdata | input | 11 | Write data |
| busy | output | 1 | A transaction is active |
| reissue | output | 1 | Pulse: repeat the attempt |
| abort_req | output | 1 | Pulse: retry budget exhausted, abort |
| xfer_err | output | 1 | Pulse: host transfer error for an aborted read |
| irq | output | 1 | Masked interrupt |
| status | output | 3 | Sticky flags: [0] retry error, [1] master abort, [2] target abort |

## Verification
The assertions assume that the retry limit is not rewritten while a transaction is active. If it were, the bound on the count could be broken legitimately. The bench writes the configuration only between transactions. It waits for busy to fall before each new start, except in the scenario that tests a start sent on purpose while busy.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    TERM_OK     = 2'b00,
    TERM_RETRY  = 2'b01,
    TERM_MABORT = 2'b10,
    TERM_TABORT = 2'b11
  } term_e;

  localparam int FLAG_N     = 3;
  localparam int FLAG_RETRY = 0;
  localparam int FLAG_MABRT = 1;
  localparam int FLAG_TABRT = 2;
endpackage

// File: rtl/rg_retry_count.sv
module rg_retry_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             exhausted
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic limit_reached(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] l);
    return (l != '0) && (c >= l);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= sat_inc(cnt);
  end

  assign exhausted = limit_reached(cnt, limit);
endmodule

// File: rtl/rg_status.sv
module rg_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                     status[i] <= 1'b0;
      else if (set[i])                status[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) status[i] <= 1'b0;
    end
  end

  assign irq = |(status & en);
endmodule

// File: rtl/retry_guard.sv
module retry_guard #(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_rd,
  input  logic                  att_valid,
  input  logic [1:0]            att_code,
  input  logic                  cfg_we,
  input  logic                  cfg_addr,
  input  logic [CNT_W+2:0]      cfg_wdata,
  output logic                  busy,
  output logic                  reissue,
  output logic                  abort_req,
  output logic                  xfer_err,
  output logic                  irq,
  output logic [rg_pkg::FLAG_N-1:0] status
);
  import rg_pkg::*;

  localparam int EN_LSB = CNT_W;
  localparam logic [CNT_W-1:0] LIMIT_RST = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  lim_q;
  logic [FLAG_N-1:0] en_q;
  logic              txn_rd;
  logic [CNT_W-1:0]  retry_cnt;
  logic              exhausted;

  // named internal events
  logic start_acc, att_fire, is_retry;
  logic ev_retry_ok, ev_retry_err, ev_mabort, ev_tabort, ev_done, ev_end, ev_abort;

  assign start_acc    = start && !busy;
  assign att_fire     = busy && att_valid;
  assign is_retry     = att_fire && (att_code == TERM_RETRY);
  assign ev_retry_ok  = is_retry && !exhausted;
  assign ev_retry_err = is_retry && exhausted;
  assign ev_mabort    = att_fire && (att_code == TERM_MABORT);
  assign ev_tabort    = att_fire && (att_code == TERM_TABORT);
  assign ev_done      = att_fire && (att_code == TERM_OK);
  assign ev_abort     = ev_retry_err || ev_mabort || ev_tabort;
  assign ev_end       = ev_abort || ev_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= LIMIT_RST;
      en_q  <= '0;
    end else if (cfg_we && !cfg_addr) begin
      lim_q <= cfg_wdata[CNT_W-1:0];
      en_q  <= cfg_wdata[EN_LSB +: FLAG_N];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      txn_rd    <= 1'b0;
      reissue   <= 1'b0;
      abort_req <= 1'b0;
      xfer_err  <= 1'b0;
    end else begin
      if (start_acc) begin
        busy   <= 1'b1;
        txn_rd <= start_rd;
      end else if (ev_end) begin
        busy   <= 1'b0;
      end
      reissue   <= ev_retry_ok;
      abort_req <= ev_retry_err;
      xfer_err  <= ev_abort && txn_rd;
    end
  end

  rg_retry_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .step(ev_retry_ok),
    .limit(lim_q), .cnt(retry_cnt), .exhausted(exhausted)
  );

  logic [FLAG_N-1:0] flag_set;
  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_RETRY] = ev_retry_err;
    flag_set[FLAG_MABRT] = ev_mabort;
    flag_set[FLAG_TABRT] = ev_tabort;
  end

  rg_status #(.N(FLAG_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(flag_set),
    .clr_we(cfg_we && cfg_addr), .clr_mask(cfg_wdata[FLAG_N-1:0]),
    .en(en_q), .status(status), .irq(irq)
  );
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             att_valid,
  input logic [1:0]       att_code,
  input logic             cfg_we,
  input logic             cfg_addr,
  input logic             busy,
  input logic             reissue,
  input logic             abort_req,
  input logic             xfer_err,
  input logic [2:0]       status,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             txn_rd
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt == '0)); // R2
  AST_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && att_valid && att_code == 2'b01 && lim == '0) |=> (reissue && !abort_req)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lim != '0) |-> (cnt <= lim)); // R4
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (!busy && status[0])); // R4
  AST_XERR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> txn_rd); // R6
  AST_XERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr) |=> ((status & $past(status)) == $past(status))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!reissue && !abort_req && !xfer_err)); // R10
endmodule

bind retry_guard rg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .att_valid(att_valid),
  .att_code(att_code), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .busy(busy),
  .reissue(reissue), .abort_req(abort_req), .xfer_err(xfer_err),
  .status(status), .cnt(retry_cnt), .lim(lim_q), .txn_rd(txn_rd)
);

// File: tb/retry_guard_tb.sv
`timescale 1ns/1ps
module retry_guard_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, start_rd = 0, att_valid = 0, cfg_we = 0, cfg_addr = 0;
  logic [1:0] att_code = 0;
  logic [10:0] cfg_wdata = 0;
  logic busy, reissue, abort_req, xfer_err, irq;
  logic [2:0] status;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  retry_guard u_dut (.*);

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [10:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // limit in [7:0], enables in [10:8]   (R11)
  task automatic set_cfg(input logic [7:0] lim, input logic [2:0] en);
    cfg_write(1'b0, {en, lim});
  endtask

  task automatic clear_all();
    cfg_write(1'b1, 11'h007);
    chk("R9 status cleared", status, 0);
  endtask

  task automatic open_txn(input logic rd, input logic exp_busy, input string tag);
    @(negedge clk); start = 1; start_rd = rd;
    @(negedge clk); start = 0;
    chk({tag, " busy after start"}, busy, exp_busy);
  endtask

  task automatic attempt(input logic [1:0] code, input logic e_re, input logic e_ab,
                         input logic e_xe, input logic e_busy, input string tag);
    @(negedge clk); att_valid = 1; att_code = code;
    @(negedge clk); att_valid = 0;
    chk({tag, " reissue"}, reissue, e_re);
    chk({tag, " abort_req"}, abort_req, e_ab);
    chk({tag, " xfer_err"}, xfer_err, e_xe);
    chk({tag, " busy"}, busy, e_busy);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pulses", {reissue, abort_req, xfer_err}, 0);
  endtask

  task automatic t_default_limit();
    open_txn(1'b0, 1'b1, "R1");
    for (int i = 0; i < 255; i++) attempt(2'b01, 1, 0, 0, 1, "R1 default retry");
    attempt(2'b01, 0, 1, 0, 0, "R1 default exhaust");
    chk("R8 masked status set", status, 1);
    chk("R1 enables off irq", irq, 0);
    clear_all();
  endtask

  task automatic t_limit_write();
    set_cfg(8'd3, 3'b111);
    open_txn(1'b0, 1'b1, "R4");
    for (int i = 0; i < 3; i++) attempt(2'b01, 1, 0, 0, 1, "R4 retry");
    attempt(2'b01, 0, 1, 0, 0, "R4 R6 write exhaust");
    chk("R4 status bit0", status, 1);
    chk("R8 irq enabled", irq, 1);
    clear_all();
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_limit_read();
    open_txn(1'b1, 1'b1, "R7");
    for (int i = 0; i < 3; i++) attempt(2'b01, 1, 0, 0, 1, "R7 retry");
    attempt(2'b01, 0, 1, 1, 0, "R7 read exhaust");
    @(negedge clk);
    chk("R7 xfer_err one cycle", xfer_err, 0);
    clear_all();
  endtask

  task automatic t_no_carry();
    open_txn(1'b0, 1'b1, "R2");
    attempt(2'b01, 1, 0, 0, 1, "R2 first txn retry");
    attempt(2'b01, 1, 0, 0, 1, "R2 first txn retry");
    attempt(2'b00, 0, 0, 0, 0, "R12 done");
    chk("R12 no status", status, 0);
    open_txn(1'b0, 1'b1, "R2");
    for (int i = 0; i < 3; i++) attempt(2'b01, 1, 0, 0, 1, "R2 fresh budget");
    attempt(2'b01, 0, 1, 0, 0, "R2 exhaust");
    clear_all();
  endtask

  task automatic t_unlimited();
    set_cfg(8'd0, 3'b111);
    open_txn(1'b1, 1'b1, "R3");
    for (int i = 0; i < 300; i++) attempt(2'b01, 1, 0, 0, 1, "R3 unlimited");
    attempt(2'b00, 0, 0, 0, 0, "R3 end");
    chk("R3 no status", status, 0);
  endtask

  task automatic t_bus_aborts();
    set_cfg(8'd1, 3'b000);
    open_txn(1'b1, 1'b1, "R5");
    attempt(2'b01, 1, 0, 0, 1, "R5 retry");
    attempt(2'b10, 0, 0, 1, 0, "R5 R7 master abort read");
    chk("R5 status bit1", status, 2);
    chk("R8 masked irq", irq, 0);
    set_cfg(8'd1, 3'b010);
    chk("R8 enable raises irq", irq, 1);
    clear_all();
    open_txn(1'b0, 1'b1, "R5");
    attempt(2'b11, 0, 0, 0, 0, "R5 R6 target abort write");
    chk("R5 status bit2", status, 4);
    chk("R8 target masked", irq, 0);
    cfg_write(1'b1, 11'h003);
    chk("R9 non-matching clear", status, 4);
    clear_all();
  endtask

  task automatic t_ignored();
    set_cfg(8'd2, 3'b000);
    attempt(2'b01, 0, 0, 0, 0, "R10 idle attempt");
    chk("R10 idle status", status, 0);
    open_txn(1'b0, 1'b1, "R10");
    attempt(2'b01, 1, 0, 0, 1, "R10 retry");
    open_txn(1'b1, 1'b1, "R10 restart");
    attempt(2'b01, 1, 0, 0, 1, "R10 retry kept count");
    attempt(2'b01, 0, 1, 0, 0, "R10 exhaust still write");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_limit();
    t_limit_write();
    t_limit_read();
    t_no_carry();
    t_unlimited();
    t_bus_aborts();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule